// File: doc/BRIEF.md
# Shift-Add Multiple Constant Multiplier

This block multiplies one signed input sample by a fixed bank of constant coefficients simultaneously, without any general multiplier. Each coefficient is a parameter that is recoded at elaboration into canonic signed digits: every digit is -1, 0 or +1, and no two neighbouring digits are both nonzero. A positive digit becomes an addition of a wired left shift of the sample. A negative digit becomes a subtraction.

Two partial sums are built once from the sample and shared by every coefficient: five times the sample (digit pair +1, 0, +1) and three times the sample (digit pair +1, 0, -1). When a coefficient has two nonzero digits two positions apart, that pair is taken from one of these shared sums, shifted into place. A coefficient may reuse a shared sum at several shifts, and all coefficients read the same shared sums. The bank therefore needs fewer adders than one independent shift-add multiplier per coefficient.

Products are full precision and registered once. A valid flag comes out one cycle after the input strobe. It is meant to sit in front of the tap adders of a transposed or block FIR filter.

Top module: `shift_add_mcm`

## Requirements
- R1: When `res_vld_o` is high, every product slot holds the exact two's-complement product of the sample captured in the previous cycle and that slot's coefficient, at a width of B+CW bits.
- R2: Negative coefficients give correctly signed products, including for negative samples.
- R3: A slot whose coefficient is zero always outputs zero.
- R4: `res_vld_o` equals the value `smp_vld_i` had at the previous rising clock edge.
- R5: In a cycle where `smp_vld_i` is low, the product register is not loaded, and all slots keep their previous values.
- R6: A synchronous reset, with `rst_n` low, clears every product slot and `res_vld_o` to zero.
- R7: Product j sits in bits [j*(B+CW) +: B+CW] of `prod_o`, and coefficient j sits in bits [j*CW +: CW] of `COEFS`.
- R8: The extreme coefficients -2^(CW-1) and 2^(CW-1)-1 give exact products for the extreme samples -2^(B-1) and 2^(B-1)-1.
- R9: Samples offered with `smp_vld_i` high in consecutive cycles each produce their own products in consecutive cycles, with no loss or merging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_i | input | B | Signed input sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| prod_o | output | NCOEF*(B+CW) | Registered signed products, slot j per R7 |
| res_vld_o | output | 1 | Products valid, one cycle after the strobe |

## Verification
Two events can fall in the same cycle: a new sample being captured, and the previous sample's products being presented. Holding the strobe high on successive cycles provokes this, and the extreme samples are sent back to back. Each result is judged against its own queued behavioural product.

The opposite pairing also occurs: the strobe drops in the very cycle after a result appears, while the input keeps changing. For that case, the bench requires every slot to stay equal to the last result it accepted.

// File: rtl/mcm_pkg.sv
// Package for the shift-add constant multiplier.
// It holds the term codes and the elaboration-time recoding function.
// Assumes: coefficients fit in 32-bit int; at most 64 digit positions.
package mcm_pkg;

    // What a single digit position contributes to a product
    typedef enum int {
        TC_NONE = 0,  // no contribution
        TC_XADD = 1,  // + sample << k
        TC_XSUB = 2,  // - sample << k
        TC_PADD = 3,  // + (5*sample) << k   pattern +1 0 +1
        TC_PSUB = 4,  // - (5*sample) << k   pattern -1 0 -1
        TC_MADD = 5,  // + (3*sample) << k   pattern +1 0 -1
        TC_MSUB = 6   // - (3*sample) << k   pattern -1 0 +1
    } term_e;

    // Recode value into signed digits (non-adjacent form), pair digits two
    // apart into shared subexpressions, return the term code at 'pos'.
    function automatic int term_code(input int value, input int ndig, input int pos);
        int dig [0:63];
        bit used [0:63];
        int v;
        int c;
        int code;
        v    = value;
        code = int'(TC_NONE);
        for (int i = 0; i < 64; i++) begin
            dig[i]  = 0;
            used[i] = 1'b0;
        end
        for (int i = 0; i < ndig && i < 64; i++) begin
            if ((v & 1) != 0) begin
                dig[i] = ((v & 3) == 1) ? 1 : -1;
                v      = v - dig[i];
            end
            v = v >>> 1;
        end
        for (int i = 0; i < ndig && i < 64; i++) begin
            if (dig[i] != 0 && !used[i]) begin
                if (i + 2 < ndig && i + 2 < 64 && dig[i+2] != 0) begin
                    used[i+2] = 1'b1;
                    if (dig[i] == 1 && dig[i+2] == 1)       c = int'(TC_PADD);
                    else if (dig[i] == -1 && dig[i+2] == -1) c = int'(TC_PSUB);
                    else if (dig[i+2] == 1)                  c = int'(TC_MADD);
                    else                                     c = int'(TC_MSUB);
                end else begin
                    c = (dig[i] == 1) ? int'(TC_XADD) : int'(TC_XSUB);
                end
                if (i == pos) code = c;
            end
        end
        return code;
    endfunction

endpackage

// File: rtl/mcm_subexpr_bank.sv
// Shared subexpression bank.
// It sign-extends the sample to product width and forms 5*x and 3*x once,
// for use by every coefficient.
// Assumes: PW >= B + 3, so that 5*x cannot wrap.
module mcm_subexpr_bank #(
    parameter int B  = 12,
    parameter int PW = 22
) (
    input  logic [B-1:0]         smp_i,
    output logic signed [PW-1:0] x_ext_o,
    output logic signed [PW-1:0] x5_o,
    output logic signed [PW-1:0] x3_o
);
    localparam int EXTW = PW - B;

    // Widen the sample to full product width, keeping its sign
    always_comb x_ext_o = {{EXTW{smp_i[B-1]}}, smp_i};

    // Shared sums: pattern +1 0 +1 and pattern +1 0 -1
    always_comb begin
        x5_o = (x_ext_o <<< 2) + x_ext_o;
        x3_o = (x_ext_o <<< 2) - x_ext_o;
    end
endmodule

// File: rtl/mcm_coef_sum.sv
// Product for one constant.
// Each digit position selects a term (sample, 5x or 3x, added or
// subtracted) shifted by its position, and the terms are summed.
// Assumes: COEF fits in NDIG-1 signed bits; wrap modulo 2^PW is exact.
module mcm_coef_sum #(
    parameter int PW   = 22,
    parameter int NDIG = 11,
    parameter int COEF = 0
) (
    input  logic signed [PW-1:0] x_ext_i,
    input  logic signed [PW-1:0] x5_i,
    input  logic signed [PW-1:0] x3_i,
    output logic signed [PW-1:0] prod_o
);
    import mcm_pkg::*;

    logic signed [PW-1:0] term [NDIG];

    for (genvar k = 0; k < NDIG; k++) begin : g_dig
        localparam int CODE = term_code(COEF, NDIG, k);
        if (CODE == int'(TC_XADD)) begin : g_xa
            always_comb term[k] = x_ext_i <<< k;             // + x shifted
        end else if (CODE == int'(TC_XSUB)) begin : g_xs
            always_comb term[k] = -(x_ext_i <<< k);          // - x shifted
        end else if (CODE == int'(TC_PADD)) begin : g_pa
            always_comb term[k] = x5_i <<< k;                // + 5x shifted
        end else if (CODE == int'(TC_PSUB)) begin : g_ps
            always_comb term[k] = -(x5_i <<< k);             // - 5x shifted
        end else if (CODE == int'(TC_MADD)) begin : g_ma
            always_comb term[k] = x3_i <<< k;                // + 3x shifted
        end else if (CODE == int'(TC_MSUB)) begin : g_ms
            always_comb term[k] = -(x3_i <<< k);             // - 3x shifted
        end else begin : g_no
            always_comb term[k] = '0;                        // zero digit
        end
    end

    // Sum the selected terms into the product
    always_comb begin
        prod_o = '0;
        for (int k = 0; k < NDIG; k++) prod_o = prod_o + term[k];
    end
endmodule

// File: rtl/mcm_out_reg.sv
// Output register for the product vector and its valid flag.
// It loads only on a valid strobe and clears on synchronous reset.
// Assumes: rst_n is active low and sampled on the rising edge.
module mcm_out_reg #(
    parameter int W = 176
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         vld_o
);
    // Capture products on valid strobe, otherwise hold
    always_ff @(posedge clk) begin
        if (!rst_n)      q_o <= '0;
        else if (vld_i)  q_o <= d_i;
    end

    // Delay the valid strobe by one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // R4: valid out is the strobe one edge later
    a_r4_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_o == $past(vld_i)));

    // R5: no strobe means the products hold
    a_r5_hold_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!vld_i && $past(rst_n)) |=> $stable(q_o));
endmodule

// File: rtl/shift_add_mcm.sv
// Multiplier for a bank of constants, built from shifts and adders.
// One signed sample is multiplied by NCOEF parameter constants using
// recoded signed digits and the shared 5x/3x subexpressions. Products
// are full precision and registered once.
// Assumes: COEFS packs coefficient j at bits [j*CW +: CW], signed.
module shift_add_mcm #(
    parameter int B     = 12,
    parameter int CW    = 10,
    parameter int NCOEF = 8,
    parameter logic [NCOEF*CW-1:0] COEFS = {
        10'(-3), 10'(173), 10'(1), 10'(-93),
        10'(45), 10'(511), 10'(-512), 10'(0)}
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [B-1:0]              smp_i,
    input  logic                      smp_vld_i,
    output logic [NCOEF*(B+CW)-1:0]   prod_o,
    output logic                      res_vld_o
);
    localparam int PW   = B + CW;
    localparam int NDIG = CW + 1;
    localparam int OW   = NCOEF * PW;

    logic signed [PW-1:0] x_ext, x5, x3;
    logic [OW-1:0]        prod_comb;

    mcm_subexpr_bank #(.B(B), .PW(PW)) bank_i (
        .smp_i   (smp_i),
        .x_ext_o (x_ext),
        .x5_o    (x5),
        .x3_o    (x3)
    );

    for (genvar j = 0; j < NCOEF; j++) begin : g_coef
        localparam logic signed [CW-1:0] CJ  = COEFS[j*CW +: CW];
        localparam int                   CJI = int'(CJ);
        localparam logic signed [PW-1:0] CJX = PW'(CJ);
        logic signed [PW-1:0] p;

        mcm_coef_sum #(.PW(PW), .NDIG(NDIG), .COEF(CJI)) sum_i (
            .x_ext_i (x_ext),
            .x5_i    (x5),
            .x3_i    (x3),
            .prod_o  (p)
        );
        // Place product j in its slot (R7)
        always_comb prod_comb[j*PW +: PW] = p;

        // R1: registered product equals behavioural multiply of captured sample
        a_r1_exact_product: assert property (@(posedge clk) disable iff (!rst_n)
            (res_vld_o && $past(rst_n)) |->
            ($signed(prod_o[j*PW +: PW]) == $past(x_ext) * CJX));

        if (CJI == 0) begin : g_zero
            // R3: zero coefficient slot stays zero
            a_r3_zero_slot: assert property (@(posedge clk) disable iff (!rst_n)
                prod_o[j*PW +: PW] == '0);
        end
    end

    mcm_out_reg #(.W(OW)) oreg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (smp_vld_i),
        .d_i   (prod_comb),
        .q_o   (prod_o),
        .vld_o (res_vld_o)
    );
endmodule

// File: tb/shift_add_mcm_tb_top.sv
`timescale 1ns/1ps
module shift_add_mcm_tb_top;
    localparam int B     = 12;
    localparam int CW    = 10;
    localparam int NCOEF = 8;
    localparam int PW    = B + CW;
    localparam int OW    = NCOEF * PW;

    // Bench's own copy of the default coefficient list, slot order (R7)
    localparam int BC [NCOEF] = '{0, -512, 511, 45, -93, 1, 173, -3};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [B-1:0]  smp_i = '0;
    logic          smp_vld_i = 1'b0;
    logic [OW-1:0] prod_o;
    logic          res_vld_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [OW-1:0] sb_q [$];
    logic [OW-1:0] last_prod = '0;

    shift_add_mcm dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_i     (smp_i),
        .smp_vld_i (smp_vld_i),
        .prod_o    (prod_o),
        .res_vld_o (res_vld_o)
    );

    always #2 clk = ~clk;

    function automatic string req_of(int j);
        if (BC[j] == 0) return "R3";
        if (BC[j] == -512 || BC[j] == 511) return "R8";
        if (BC[j] < 0) return "R2";
        return "R1";
    endfunction

    // Driver: apply one sample at the falling edge, queue its expected products
    task automatic drive(input logic [B-1:0] x, input logic v);
        logic [OW-1:0] e;
        @(negedge clk);
        smp_i     = x;
        smp_vld_i = v;
        if (v) begin
            for (int j = 0; j < NCOEF; j++) begin
                longint p;
                p = longint'($signed(x)) * longint'(BC[j]);
                e[j*PW +: PW] = p[PW-1:0];
            end
            sb_q.push_back(e);
        end
    endtask

    // Monitor: after each rising edge, check the valid flag, then either
    // compare a popped result or check that the outputs held
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            n_chk++;
            if (res_vld_o !== smp_vld_i) begin
                n_bad++;
                $display("FAIL R4 valid: got %b exp %b", res_vld_o, smp_vld_i);
            end
            if (res_vld_o) begin
                if (sb_q.size() == 0) begin
                    n_chk++; n_bad++;
                    $display("FAIL R9 unexpected result: got %h exp none", prod_o);
                end else begin
                    logic [OW-1:0] e;
                    e = sb_q.pop_front();
                    for (int j = 0; j < NCOEF; j++) begin   // per-slot compare, R7
                        n_chk++;
                        if (prod_o[j*PW +: PW] !== e[j*PW +: PW]) begin
                            n_bad++;
                            $display("FAIL %s slot %0d coef %0d: got %h exp %h",
                                     req_of(j), j, BC[j], prod_o[j*PW +: PW], e[j*PW +: PW]);
                        end
                    end
                    last_prod = prod_o;
                end
            end else begin
                n_chk++;
                if (prod_o !== last_prod) begin
                    n_bad++;
                    $display("FAIL R5 hold: got %h exp %h", prod_o, last_prod);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: got hang exp finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R6: reset clears outputs even with a strobe present
        smp_vld_i = 1'b1;
        smp_i     = 12'h7FF;
        repeat (3) @(negedge clk);
        n_chk++;
        if (prod_o !== '0 || res_vld_o !== 1'b0) begin
            n_bad++;
            $display("FAIL R6 reset: got %h/%b exp 0/0", prod_o, res_vld_o);
        end
        smp_vld_i = 1'b0;
        rst_n     = 1'b1;
        // R8, R9: extreme and simple samples back to back
        drive(12'h800, 1'b1);
        drive(12'h7FF, 1'b1);
        drive(12'h000, 1'b1);
        drive(12'h001, 1'b1);
        drive(12'hFFF, 1'b1);
        drive(12'h800, 1'b1);
        // R5: strobe low while the sample moves
        drive(12'h123, 1'b0);
        drive(12'h7FF, 1'b0);
        drive(12'h800, 1'b0);
        drive(12'h7FF, 1'b1);
        // R1, R2: random samples with random strobe
        for (int i = 0; i < 400; i++) begin
            drive(B'($urandom), 1'($urandom_range(0, 3) != 0));
        end
        drive('0, 1'b0);
        drive('0, 1'b0);
        @(negedge clk);
        n_chk++;
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9 lost results: got %0d pending exp 0", sb_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule